// File: doc/BRIEF.md
# Strobe-Loaded Pulse-Width Modulator

This block turns a stream of unsigned PCM samples into one pulse-width modulated drive bit for a switching output stage. A sample strobe opens a switching period of exactly 2^SAMPLE_W bit-clock cycles. The strobe loads the sample into a width down-counter and sets an output latch. When the counter runs out, the latch clears, so the high time in bit clocks equals the sample value. The bit clock must therefore run at 2^SAMPLE_W times the sample rate, and the switching rate equals the sample rate.

A mode input is captured with each sample. In trailing mode the pulse starts at the period boundary and its falling edge moves with the sample. In leading mode the carrier is mirrored: the output waits, rises, and stays high up to the end of the period. A terminal-count flag marks the last cycle of every period. A strobe in that same cycle chains the next period with no gap. A strobe at any earlier point of a running period is dropped.

Top module: `pcm_pwm_gen`

## Requirements
- R1: During reset and in the first cycle after it, `pwm_out` and `term_cnt` are 0 and no period is running.
- R2: An accepted strobe starts a period of exactly 2^SAMPLE_W cycles, counted from the cycle after the strobe edge. `term_cnt` is 1 only in the last of those cycles.
- R3: In trailing mode (`lead_mode`=0) with sample s, `pwm_out` is 1 in period cycles 0 to s-1 and 0 for the rest of the period.
- R4: A sample of 0 gives no high cycle in either mode. A sample of all ones gives 2^SAMPLE_W-1 high cycles.
- R5: In leading mode (`lead_mode`=1) with sample s, `pwm_out` is 0 for the first 2^SAMPLE_W-s cycles and 1 from there to the end of the period.
- R6: A strobe while a period runs and `term_cnt` is 0 is ignored. The running period keeps its sample, length and waveform.
- R7: A strobe in the cycle where `term_cnt` is 1 is accepted. The new period begins in the very next cycle.
- R8: If no strobe arrives by the end of a period, the block goes idle: `pwm_out` and `term_cnt` stay 0 until the next strobe.
- R9: `lead_mode` is sampled only when a strobe is accepted. Changing it during a period has no effect on that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 2^SAMPLE_W times the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample strobe, one cycle |
| smp_data | input | SAMPLE_W | Unsigned sample, taken with the strobe |
| lead_mode | input | 1 | 0 = trailing edge, 1 = leading edge, taken with the strobe |
| pwm_out | output | 1 | Modulated drive bit |
| term_cnt | output | 1 | High in the last cycle of a period |

## Verification
The end of one period and the start of the next can fall in the same cycle. This happens when a strobe arrives in the cycle where `term_cnt` is high. In the same edge the period counter must reload and the output latch must take its new value instead of being cleared. The bench provokes this by chaining periods back to back. The chains include mode changes and the extreme samples 0 and all ones. A leading-mode pulse that is still high at the boundary is followed by a trailing-mode pulse that must rise again in cycle 0. The bench judges every cycle of both periods against the waveform computed from the sample. It also checks that no idle cycle appears between the two periods.

// File: rtl/pcm_pwm_pkg.sv
// Shared types for the strobe-loaded pulse-width modulator.
package pcm_pwm_pkg;
    // Which period boundary the pulse is anchored to.
    typedef enum logic {
        EDGE_TRAIL = 1'b0,
        EDGE_LEAD  = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/pcm_pwm_period_timer.sv
// Period timer: counts one switching period of 2^SAMPLE_W cycles after an
// accepted strobe. It decides whether a strobe is accepted and flags the
// last cycle of the period.
// Assumes: strobes are single-cycle pulses; reset is synchronous, active low.
module pcm_pwm_period_timer #(
    parameter int SAMPLE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic accept,
    output logic active,
    output logic last
);
    localparam logic [SAMPLE_W-1:0] PER_TOP = {SAMPLE_W{1'b1}};

    logic [SAMPLE_W-1:0] pcnt_q;
    logic                busy_q;

    // Last cycle of a running period, and strobe acceptance.
    always_comb begin
        last   = busy_q && (pcnt_q == '0);
        accept = strobe && (!busy_q || last);
        active = busy_q;
    end

    // Period position counter and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            busy_q <= 1'b0;
        end else if (accept) begin
            pcnt_q <= PER_TOP;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (pcnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    // R6
    mid_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && busy_q && pcnt_q != '0) |=> (busy_q && pcnt_q == $past(pcnt_q) - 1'b1));

    // R7
    chain_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && last) |=> (busy_q && pcnt_q == PER_TOP));

    // R8
    idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !strobe) |=> !busy_q);
endmodule

// File: rtl/pcm_pwm_width_latch.sv
// Width counter and output latch. On load the sample (trailing mode) or its
// complement (leading mode, mirrored carrier) enters the down-counter. In
// trailing mode the latch is set at load and cleared as the count hits zero.
// In leading mode the latch is set once the count is exhausted and held to
// the period end.
// Assumes: load and stop are never high together; active marks a running period.
module pcm_pwm_width_latch #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                stop,
    input  logic                active,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                lead,
    output logic                pwm
);
    import pcm_pwm_pkg::*;

    logic [SAMPLE_W-1:0] wcnt_q;
    edge_mode_e          mode_q;
    logic                pwm_q;

    // Load, count down and set/clear the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            mode_q <= EDGE_TRAIL;
            pwm_q  <= 1'b0;
        end else if (load) begin
            mode_q <= edge_mode_e'(lead);
            wcnt_q <= lead ? ~sample : sample;
            pwm_q  <= lead ? 1'b0 : (sample != '0);
        end else if (stop) begin
            wcnt_q <= '0;
            pwm_q  <= 1'b0;
        end else if (active) begin
            if (wcnt_q != '0) begin
                wcnt_q <= wcnt_q - 1'b1;
            end
            if (mode_q == EDGE_LEAD) begin
                if (wcnt_q == '0) pwm_q <= 1'b1;
            end else if (wcnt_q == {{(SAMPLE_W-1){1'b0}}, 1'b1}) begin
                pwm_q <= 1'b0;
            end
        end
    end

    assign pwm = pwm_q;

    // R3
    trail_rise_only_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && mode_q == EDGE_TRAIL) |=> !$rose(pwm_q));

    // R5
    lead_hold_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !stop && mode_q == EDGE_LEAD) |=> !$fell(pwm_q));
endmodule

// File: rtl/pcm_pwm_gen.sv
// Top of the strobe-loaded pulse-width modulator. The period timer takes
// strobes; the width latch forms the pulse inside each period.
// Assumes: clk runs at 2^SAMPLE_W times the sample rate; reset is
// synchronous, active low.
module pcm_pwm_gen #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                lead_mode,
    output logic                pwm_out,
    output logic                term_cnt
);
    logic accept;
    logic active;
    logic last;
    logic stop;

    // Period ends without a follow-on sample.
    always_comb stop = last && !accept;

    pcm_pwm_period_timer #(.SAMPLE_W(SAMPLE_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (smp_stb),
        .accept (accept),
        .active (active),
        .last   (last)
    );

    pcm_pwm_width_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .stop   (stop),
        .active (active),
        .sample (smp_data),
        .lead   (lead_mode),
        .pwm    (pwm_out)
    );

    assign term_cnt = last;

    // R8
    idle_output_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!pwm_out && !term_cnt));

    // R2
    term_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |=> !term_cnt);
endmodule

// File: tb/tb_pcm_pwm_gen.sv
module tb_pcm_pwm_gen;
    localparam int SW = 8;
    localparam int NP = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_stb = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          lead_mode = 1'b0;
    logic          pwm_out;
    logic          term_cnt;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    pcm_pwm_gen #(.SAMPLE_W(SW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_data  (smp_data),
        .lead_mode (lead_mode),
        .pwm_out   (pwm_out),
        .term_cnt  (term_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Present a strobe at the current falling edge; return at falling edge of cycle 0.
    task automatic start(input int s, input bit lead);
        smp_stb   = 1'b1;
        smp_data  = SW'(s);
        lead_mode = lead;
        @(negedge clk);
        smp_stb   = 1'b0;
    endtask

    // Check one whole period; optionally inject a stray strobe at cycle inj.
    // Returns at the falling edge of the last cycle of the period.
    task automatic watch(input int s, input bit lead, input int inj, input string tag);
        for (int k = 0; k < NP; k++) begin
            bit e;
            e = lead ? (k >= NP - s) : (k < s);
            if (k == inj + 1) smp_stb = 1'b0;
            check(pwm_out == e, $sformatf("%s pwm cycle %0d", tag, k), pwm_out, e);
            check(term_cnt == (k == NP - 1), $sformatf("R2 term cycle %0d", k), term_cnt, k == NP - 1);
            if (k == inj) begin
                smp_stb   = 1'b1;
                smp_data  = ~SW'(s);
                lead_mode = ~lead;
            end
            if (k < NP - 1) @(negedge clk);
        end
    endtask

    task automatic idle_check(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(pwm_out == 1'b0, "R8 idle pwm", pwm_out, 0);
            check(term_cnt == 1'b0, "R8 idle term", term_cnt, 0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm in reset", pwm_out, 0);
        check(term_cnt == 1'b0, "R1 term in reset", term_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
        check(term_cnt == 1'b0, "R1 term after reset", term_cnt, 0);
    endtask

    task automatic t_single_trail;
        start(64, 1'b0);
        watch(64, 1'b0, -2, "R3 trail s=64");
        idle_check(5);
    endtask

    task automatic t_chain;
        start(0, 1'b0);
        watch(0, 1'b0, -2, "R4 trail s=0");
        start(NP - 1, 1'b0);
        watch(NP - 1, 1'b0, -2, "R7 R4 trail all ones");
        start(48, 1'b1);
        watch(48, 1'b1, -2, "R7 R5 lead s=48");
        start(NP - 1, 1'b1);
        watch(NP - 1, 1'b1, -2, "R4 R5 lead all ones");
        start(0, 1'b1);
        watch(0, 1'b1, -2, "R4 lead s=0");
        start(100, 1'b1);
        watch(100, 1'b1, -2, "R5 lead s=100");
        start(7, 1'b0);
        watch(7, 1'b0, -2, "R7 trail after lead");
        idle_check(4);
    endtask

    task automatic t_stray;
        start(128, 1'b0);
        watch(128, 1'b0, 10, "R6 R9 stray strobe trail");
        start(32, 1'b1);
        watch(32, 1'b1, 200, "R6 R9 stray strobe lead");
        idle_check(3);
        start(1, 1'b0);
        watch(1, 1'b0, -2, "R3 trail s=1");
        idle_check(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_trail();
        t_chain();
        t_stray();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule